// File: doc/BRIEF.md
# Generator-Polynomial Encoder and Remainder Checker

This block holds two parallel datapaths for a binary linear block code built on a generator polynomial g(x). The encoder takes a DATA_W-bit value, reads it as a polynomial over GF(2) and multiplies it by g(x). The result is an N-bit codeword, where N = DATA_W + CHK_W and CHK_W is the degree of g(x). The checker takes an N-bit word and divides it by g(x). It returns the quotient and the remainder, and raises an error flag whenever the remainder is not zero. When the word is a valid codeword, the quotient is the original data.

The code is not required to be cyclic, so g(x) does not have to divide x^N − 1. The only constraint on g(x) is that its constant term and its leading term are both 1. A typical use wraps a datapath whose operations keep codewords closed, such as XOR and scalar AND. Operands are encoded on the way in, and the result is checked and decoded on the way out. An error is modelled as a vector XORed onto a correct word. Any error vector that is itself a nonzero codeword passes the check unseen.

Both paths are combinational. The parameter REG_OUT adds one register stage on all outputs, with an asynchronous active-low reset.

Top module: `lc_codec`

## Requirements
- R1: enc_o equals the GF(2) polynomial product of data_i and GEN, where bit i of each vector is the coefficient of x^i.
- R2: When word_i is a codeword (the product of some data d and GEN), rem_o is 0, err_o is 0 and quot_o equals d.
- R3: rem_o equals word_i mod GEN over GF(2), and err_o is 1 exactly when rem_o is nonzero.
- R4: quot_o equals the GF(2) quotient floor(word_i / GEN) for any word_i, so that quot_o·GEN XOR rem_o equals word_i.
- R5: A codeword with any single bit inverted always gives err_o = 1.
- R6: A codeword XORed with a nonzero error vector that is itself a codeword gives err_o = 0. In that case quot_o is the XOR of the two underlying data values.
- R7: The encoding is linear: enc(a XOR b) equals enc(a) XOR enc(b).
- R8: With REG_OUT = 1, every output shows the result for the inputs present at the previous rising clk_i edge. While rst_ni is low, all outputs are 0.
- R9: A data_i of 0 encodes to an all-zero codeword, and the all-zero word checks clean with quotient 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | DATA_W | Value to encode |
| word_i | input | DATA_W+CHK_W | Word to check and decode |
| enc_o | output | DATA_W+CHK_W | Codeword data_i·g(x) |
| quot_o | output | DATA_W | Quotient word_i / g(x) |
| rem_o | output | CHK_W | Remainder word_i mod g(x) |
| err_o | output | 1 | High when the remainder is nonzero |

## Verification
Every single-bit flip is injected at each of the N positions of a random codeword. A divider that skips its top or bottom stage would miss flips at the ends of the word. Error vectors that are themselves codewords are injected as well: a checker that flags them, or that returns a quotient other than the XOR of the two data values, is not dividing by g(x). Arbitrary words with nonzero remainders check that the quotient and remainder recombine to the input, which catches a subtraction aligned to the wrong bit. A new input is also checked to stay invisible until the next clock edge, which catches a register stage that has been bypassed.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned LC_DATA_W = 16;
  localparam int unsigned LC_CHK_W  = 8;
  // x^8 + x^2 + x + 1
  localparam logic [LC_CHK_W:0] LC_GEN = 9'h107;
endpackage

// File: rtl/lc_encoder.sv
module lc_encoder #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHK_W  = 8,
  parameter logic [CHK_W:0] GEN = '1
) (
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W+CHK_W-1:0] enc_o
);
  localparam int unsigned N = DATA_W + CHK_W;
  localparam logic [N-1:0] GEN_EXT = {{(DATA_W-1){1'b0}}, GEN};

  logic [N-1:0] part [DATA_W+1];
  assign part[0] = '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_term
    assign part[i+1] = part[i] ^ (data_i[i] ? (GEN_EXT << i) : '0);
  end

  assign enc_o = part[DATA_W];
endmodule

// File: rtl/lc_divider.sv
module lc_divider #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHK_W  = 8,
  parameter logic [CHK_W:0] GEN = '1
) (
  input  logic [DATA_W+CHK_W-1:0] word_i,
  output logic [DATA_W-1:0]       quot_o,
  output logic [CHK_W-1:0]        rem_o,
  output logic                    err_o
);
  localparam int unsigned N = DATA_W + CHK_W;
  localparam logic [N-1:0] GEN_EXT = {{(DATA_W-1){1'b0}}, GEN};

  // one conditional-subtract stage per quotient bit, MSB first
  logic [N-1:0] part [DATA_W+1];
  assign part[0] = word_i;

  for (genvar k = 0; k < DATA_W; k++) begin : g_stage
    localparam int unsigned TOP = N - 1 - k;
    localparam int unsigned SH  = DATA_W - 1 - k;
    assign quot_o[SH]  = part[k][TOP];
    assign part[k+1]   = part[k] ^ (part[k][TOP] ? (GEN_EXT << SH) : '0);
  end

  assign rem_o = part[DATA_W][CHK_W-1:0];
  assign err_o = |rem_o;
endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/lc_codec.sv
module lc_codec
  import lc_pkg::*;
#(
  parameter int unsigned DATA_W  = LC_DATA_W,
  parameter int unsigned CHK_W   = LC_CHK_W,
  parameter logic [CHK_W:0] GEN  = LC_GEN,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [DATA_W+CHK_W-1:0] word_i,
  output logic [DATA_W+CHK_W-1:0] enc_o,
  output logic [DATA_W-1:0]       quot_o,
  output logic [CHK_W-1:0]        rem_o,
  output logic                    err_o
);
  localparam int unsigned N   = DATA_W + CHK_W;
  localparam int unsigned OUT_W = N + DATA_W + CHK_W + 1;

  logic [N-1:0]      enc_c;
  logic [DATA_W-1:0] quot_c;
  logic [CHK_W-1:0]  rem_c;
  logic              err_c;

  lc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .GEN(GEN)) u_enc (
    .data_i (data_i),
    .enc_o  (enc_c)
  );

  lc_divider #(.DATA_W(DATA_W), .CHK_W(CHK_W), .GEN(GEN)) u_div (
    .word_i (word_i),
    .quot_o (quot_c),
    .rem_o  (rem_c),
    .err_o  (err_c)
  );

  lc_out_stage #(.W(OUT_W), .REG(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_c, quot_c, rem_c, err_c}),
    .q_o    ({enc_o, quot_o, rem_o, err_o})
  );
endmodule

// File: rtl/lc_codec_chk.sv
module lc_codec_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CHK_W   = 8,
  parameter logic [CHK_W:0] GEN  = '1,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [DATA_W-1:0]       data_i,
  input logic [DATA_W+CHK_W-1:0] word_i,
  input logic [DATA_W+CHK_W-1:0] enc_o,
  input logic [DATA_W-1:0]       quot_o,
  input logic [CHK_W-1:0]        rem_o,
  input logic                    err_o
);
  localparam int unsigned N = DATA_W + CHK_W;

  function automatic logic [N-1:0] pmul(input logic [DATA_W-1:0] d);
    logic [N-1:0] acc;
    acc = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) acc ^= ({{(DATA_W-1){1'b0}}, GEN} << i);
    return acc;
  endfunction

  logic              seen_q;
  logic [DATA_W-1:0] data_q;
  logic [N-1:0]      word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      data_q <= '0;
      word_q <= '0;
    end else begin
      seen_q <= 1'b1;
      data_q <= data_i;
      word_q <= word_i;
    end
  end

  logic [DATA_W-1:0] data_ref;
  logic [N-1:0]      word_ref;
  assign data_ref = REG_OUT ? data_q : data_i;
  assign word_ref = REG_OUT ? word_q : word_i;

  AST_ERR_FROM_REM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (rem_o != '0)); // R3

  AST_ENC_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> enc_o == pmul(data_ref)); // R1

  AST_RECOMBINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (pmul(quot_o) ^ {{DATA_W{1'b0}}, rem_o}) == word_ref); // R4

  AST_CLEAN_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && word_ref == pmul(data_ref)) |-> (!err_o && quot_o == data_ref)); // R2

  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && word_ref == '0) |-> (quot_o == '0 && !err_o)); // R9
endmodule

bind lc_codec lc_codec_chk #(
  .DATA_W(DATA_W), .CHK_W(CHK_W), .GEN(GEN), .REG_OUT(REG_OUT)
) u_lc_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .data_i (data_i),
  .word_i (word_i),
  .enc_o  (enc_o),
  .quot_o (quot_o),
  .rem_o  (rem_o),
  .err_o  (err_o)
);

// File: tb/lc_codec_tb_top.sv
module lc_codec_tb_top;
  localparam int unsigned M = 16;
  localparam int unsigned R = 8;
  localparam int unsigned N = M + R;
  localparam logic [R:0] G = 9'h107;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [M-1:0] data_i = '0;
  logic [N-1:0] word_i = '0;
  logic [N-1:0] enc_o;
  logic [M-1:0] quot_o;
  logic [R-1:0] rem_o;
  logic         err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  lc_codec #(.DATA_W(M), .CHK_W(R), .GEN(G), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .word_i(word_i),
    .enc_o(enc_o), .quot_o(quot_o), .rem_o(rem_o), .err_o(err_o)
  );

  function automatic logic [N-1:0] ref_mul(input logic [M-1:0] d);
    logic [N-1:0] acc = '0;
    for (int i = 0; i < M; i++)
      if (d[i]) acc ^= (N'(G) << i);
    return acc;
  endfunction

  function automatic logic [N-1:0] ref_rem(input logic [N-1:0] w);
    logic [N-1:0] t = w;
    for (int b = N - 1; b >= int'(R); b--)
      if (t[b]) t ^= (N'(G) << (b - R));
    return t;
  endfunction

  function automatic logic [M-1:0] ref_quot(input logic [N-1:0] w);
    logic [N-1:0] t = w;
    logic [M-1:0] q = '0;
    for (int b = N - 1; b >= int'(R); b--)
      if (t[b]) begin
        q[b-R] = 1'b1;
        t ^= (N'(G) << (b - R));
      end
    return q;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [M-1:0] d, input logic [N-1:0] w);
    @(negedge clk_i);
    data_i = d;
    word_i = w;
    @(posedge clk_i);
    #1;
  endtask

  task automatic full_check(input logic [M-1:0] d, input logic [N-1:0] w);
    logic [N-1:0] e_enc = ref_mul(d);
    logic [N-1:0] e_rem = ref_rem(w);
    logic [M-1:0] e_q = ref_quot(w);
    apply(d, w);
    chk(enc_o == e_enc, "R1 enc", 32'(enc_o), 32'(e_enc));
    chk(rem_o == e_rem[R-1:0], "R3 rem", 32'(rem_o), 32'(e_rem[R-1:0]));
    chk(err_o == (e_rem != '0), "R3 err", 32'(err_o), 32'(e_rem != '0));
    chk(quot_o == e_q, "R4 quot", 32'(quot_o), 32'(e_q));
  endtask

  logic done = 1'b0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] d, d2, a, b;
    logic [N-1:0] cw, ea, eb;
    process::self().srandom(32'h1c0de);

    // R8 reset: outputs cleared despite live inputs
    data_i = 16'hbeef;
    word_i = 24'h123457;
    repeat (3) @(posedge clk_i);
    #1;
    chk(enc_o == '0 && quot_o == '0 && rem_o == '0 && !err_o, "R8 reset",
        32'(enc_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 zero
    apply('0, '0);
    chk(enc_o == '0, "R9 enc zero", 32'(enc_o), 32'h0);
    chk(quot_o == '0 && !err_o, "R9 check zero", 32'(quot_o), 32'h0);

    // directed corners
    full_check(16'h0001, ref_mul(16'h0001));
    chk(enc_o == N'(G), "R1 data=1 gives generator", 32'(enc_o), 32'(G));
    full_check('1, ref_mul('1));
    full_check(16'h8000, 24'h800000);
    full_check('0, 24'h000001);

    // R8 latency: new input not visible before next edge
    apply(16'h1234, ref_mul(16'h1234));
    ea = enc_o;
    @(negedge clk_i);
    data_i = 16'h4321;
    word_i = 24'hffffff;
    #1;
    chk(enc_o == ea, "R8 held until edge", 32'(enc_o), 32'(ea));
    @(posedge clk_i);
    #1;
    chk(enc_o == ref_mul(16'h4321), "R8 updated after edge", 32'(enc_o),
        32'(ref_mul(16'h4321)));

    // R1/R2 random codewords
    for (int i = 0; i < 200; i++) begin
      d = M'($urandom);
      cw = ref_mul(d);
      full_check(d, cw);
      chk(!err_o && rem_o == '0 && quot_o == d, "R2 clean decode", 32'(quot_o), 32'(d));
    end

    // R3/R4 arbitrary words
    for (int i = 0; i < 200; i++) full_check(M'($urandom), N'($urandom));

    // R5 every single-bit flip
    d = M'($urandom);
    cw = ref_mul(d);
    for (int p = 0; p < int'(N); p++) begin
      apply(d, cw ^ (N'(1) << p));
      chk(err_o == 1'b1, $sformatf("R5 flip bit %0d", p), 32'(err_o), 32'h1);
    end

    // R6 codeword-shaped errors escape
    for (int i = 0; i < 40; i++) begin
      d = M'($urandom);
      d2 = M'($urandom) | 16'h0001;
      apply(d, ref_mul(d) ^ ref_mul(d2));
      chk(err_o == 1'b0, "R6 undetected err", 32'(err_o), 32'h0);
      chk(quot_o == (d ^ d2), "R6 quot", 32'(quot_o), 32'(d ^ d2));
    end

    // R7 linearity
    for (int i = 0; i < 20; i++) begin
      a = M'($urandom);
      b = M'($urandom);
      apply(a, '0);
      ea = enc_o;
      apply(b, '0);
      eb = enc_o;
      apply(a ^ b, '0);
      chk(enc_o == (ea ^ eb), "R7 linear", 32'(enc_o), 32'(ea ^ eb));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule